// File: doc/BRIEF.md
# Vector Bit-Reverse and Shuffle Permuter

This unit reorders the elements of a 64-element vector in one pass. It takes one source vector, or two for the 128-element modes, together with an operation code and a range given as a first and last quarter. It produces a permuted destination vector. It supports bit-reversed index ordering inside aligned groups of 16, 32 or 64 elements. It also supports a perfect-shuffle interleave of the two halves of each 32- or 64-element group. Finally, it has a 128-element interleave and its inverse, which treat two registers as one long vector, with the first register holding the lower 64 positions. These orderings are used between the stages of a vectorised FFT. For example, real and imaginary planes can be interleaved into complex pairs and split back again.

Operations are accepted with a valid/ready handshake and return their result from a register one cycle later. A range that does not fit the chosen operation is rejected with a flag, and the destination registers keep their previous contents. Element width is a parameter.

Top module: `vperm_shuffle_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_illegal` clear and both destination vectors become all zeros. After reset, `in_ready` is high.
- R2: `in_ready` equals `!out_valid || out_ready`. An operation accepted at an edge shows `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, the outputs hold unchanged and no new operation is taken.
- R3: Operation code 2 (reverse-64) requires quarters 0 to 3. Destination index with bits abcdef takes the source element at fedcba.
- R4: Operation code 1 (reverse-32) requires an even first quarter and an odd last quarter, selecting one or both halves. Inside each selected half, the low five index bits are reversed and bit 5 is kept.
- R5: Operation code 0 (reverse-16) accepts any contiguous run of quarters. Inside each selected quarter, the low four index bits are reversed, giving the order 0 8 4 12 2 10 6 14 1 9 5 13 3 11 7 15.
- R6: Operation codes 3 (shuffle-32, same range rule as R4) and 4 (shuffle-64, same as R3) interleave the lower and upper half of each group. Destination 2k takes source k, and destination 2k+1 takes source k plus half the group size.
- R7: Operation code 5 (shuffle-128) requires quarters 0 to 3. It views `{src_b, src_a}` as 128 elements and writes `{dst_b, dst_a}` with destination 2k taking element k and destination 2k+1 taking element 64+k.
- R8: Operation code 6 (unshuffle-128) requires quarters 0 to 3. `dst_a[k]` takes combined element 2k and `dst_b[k]` takes combined element 2k+1.
- R9: In the single-register modes, elements of `dst_a` outside the selected quarters equal the source elements at the same index.
- R10: A range whose first quarter exceeds its last quarter, a range that breaks the rule of its operation, or operation code 7 produces `out_illegal` high with the result. In that case both destination vectors keep their prior values.
- R11: In the single-register modes (codes 0 to 4), `dst_b` equals `src_b`.
- R12: Applying any bit-reverse twice with the same range returns the original vector. Shuffle-128 followed by unshuffle-128 returns the original pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op | input | 3 | Operation code (0 to 6, 7 reserved) |
| range_lo | input | 2 | First selected quarter |
| range_hi | input | 2 | Last selected quarter |
| src_a | input | 64*ELEM_W | First source vector, element i at bits i*ELEM_W |
| src_b | input | 64*ELEM_W | Second source vector (upper half of 128-element modes) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_illegal | output | 1 | Rejected operation, destination unchanged |
| dst_a | output | 64*ELEM_W | First destination vector |
| dst_b | output | 64*ELEM_W | Second destination vector |

## Verification
The properties assume that `in_valid` and the operands are held only as the handshake requires. They also assume that `rst` is asserted for at least one edge before the first operation. The stimulus raises `in_valid` for exactly one accepted edge and changes inputs only on falling clock edges. When the output is stalled, it keeps offering the same operation until `in_ready` returns. Operation codes and ranges are chosen so that every legality branch is covered: legal runs, reversed bounds, misaligned halves, partial ranges for whole-vector modes and the reserved code.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  localparam int VP_NELEM = 64;
  localparam int VP_NPOS  = 2 * VP_NELEM;
  localparam int VP_IDX_W = $clog2(VP_NPOS);
  localparam int VP_NQ    = 4;
  localparam int VP_QW    = $clog2(VP_NQ);

  typedef enum logic [2:0] {
    OP_REV16  = 3'd0,
    OP_REV32  = 3'd1,
    OP_REV64  = 3'd2,
    OP_SHF32  = 3'd3,
    OP_SHF64  = 3'd4,
    OP_SHF128 = 3'd5,
    OP_UNS128 = 3'd6,
    OP_RSVD   = 3'd7
  } vp_op_e;

  function automatic logic vp_is_pair(input vp_op_e o);
    return (o == OP_SHF128) || (o == OP_UNS128);
  endfunction

endpackage

// File: rtl/vperm_range_chk.sv
module vperm_range_chk
  import vperm_pkg::*;
(
  input  vp_op_e                 op,
  input  logic [VP_QW-1:0]       range_lo,
  input  logic [VP_QW-1:0]       range_hi,
  output logic                   legal,
  output logic [VP_NQ-1:0]       qsel
);

  localparam logic [VP_QW-1:0] Q_LAST = VP_QW'(VP_NQ - 1);

  logic ordered;
  logic half_aligned;
  logic full_span;

  assign ordered      = (range_lo <= range_hi);
  assign half_aligned = (range_lo[0] == 1'b0) && (range_hi[0] == 1'b1);
  assign full_span    = (range_lo == '0) && (range_hi == Q_LAST);

  always_comb begin
    unique case (op)
      OP_REV16:                      legal = ordered;
      OP_REV32, OP_SHF32:            legal = ordered && half_aligned;
      OP_REV64, OP_SHF64,
      OP_SHF128, OP_UNS128:          legal = full_span;
      default:                       legal = 1'b0;
    endcase
  end

  for (genvar q = 0; q < VP_NQ; q++) begin : g_q
    localparam logic [VP_QW-1:0] QI = VP_QW'(q);
    assign qsel[q] = (QI >= range_lo) && (QI <= range_hi);
  end

endmodule

// File: rtl/vperm_index_map.sv
module vperm_index_map
  import vperm_pkg::*;
(
  input  vp_op_e                         op,
  input  logic [VP_NQ-1:0]               qsel,
  output logic [VP_NPOS*VP_IDX_W-1:0]    src_idx
);

  for (genvar e = 0; e < VP_NPOS; e++) begin : g_pos
    localparam logic [VP_IDX_W-1:0] EI = VP_IDX_W'(e);
    logic [5:0]          d;
    logic                upper;
    logic                in_sel;
    logic [VP_IDX_W-1:0] sidx;

    assign d      = EI[5:0];
    assign upper  = EI[6];
    assign in_sel = qsel[EI[5:4]] && !upper;

    always_comb begin
      sidx = EI;
      unique case (op)
        OP_REV16: if (in_sel) sidx = {1'b0, d[5:4], d[0], d[1], d[2], d[3]};
        OP_REV32: if (in_sel) sidx = {1'b0, d[5], d[0], d[1], d[2], d[3], d[4]};
        OP_REV64: if (in_sel) sidx = {1'b0, d[0], d[1], d[2], d[3], d[4], d[5]};
        OP_SHF32: if (in_sel) sidx = {1'b0, d[5], d[0], d[4:1]};
        OP_SHF64: if (in_sel) sidx = {1'b0, d[0], d[5:1]};
        OP_SHF128:            sidx = {EI[0], EI[6:1]};
        OP_UNS128:            sidx = {EI[5:0], EI[6]};
        default:              sidx = EI;
      endcase
    end

    assign src_idx[e*VP_IDX_W +: VP_IDX_W] = sidx;
  end

endmodule

// File: rtl/vperm_xbar.sv
module vperm_xbar
  import vperm_pkg::*;
#(
  parameter int ELEM_W = 16
) (
  input  logic [VP_NPOS*ELEM_W-1:0]    src,
  input  logic [VP_NPOS*VP_IDX_W-1:0]  src_idx,
  output logic [VP_NPOS*ELEM_W-1:0]    dst
);

  for (genvar e = 0; e < VP_NPOS; e++) begin : g_out
    logic [VP_IDX_W-1:0] sel;
    assign sel = src_idx[e*VP_IDX_W +: VP_IDX_W];
    assign dst[e*ELEM_W +: ELEM_W] = src[int'(sel)*ELEM_W +: ELEM_W];
  end

endmodule

// File: rtl/vperm_shuffle_unit.sv
module vperm_shuffle_unit
  import vperm_pkg::*;
#(
  parameter int ELEM_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [2:0]                   op,
  input  logic [1:0]                   range_lo,
  input  logic [1:0]                   range_hi,
  input  logic [VP_NELEM*ELEM_W-1:0]   src_a,
  input  logic [VP_NELEM*ELEM_W-1:0]   src_b,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic                         out_illegal,
  output logic [VP_NELEM*ELEM_W-1:0]   dst_a,
  output logic [VP_NELEM*ELEM_W-1:0]   dst_b
);

  localparam int VEC_W = VP_NELEM * ELEM_W;

  vp_op_e                        op_e;
  logic                          legal;
  logic [VP_NQ-1:0]              qsel;
  logic [VP_NPOS*VP_IDX_W-1:0]   src_idx;
  logic [2*VEC_W-1:0]            perm;
  logic                          accept;

  assign op_e   = vp_op_e'(op);
  assign accept = in_valid && in_ready;

  vperm_range_chk u_rchk (
    .op       (op_e),
    .range_lo (range_lo),
    .range_hi (range_hi),
    .legal    (legal),
    .qsel     (qsel)
  );

  vperm_index_map u_map (
    .op      (op_e),
    .qsel    (qsel),
    .src_idx (src_idx)
  );

  vperm_xbar #(.ELEM_W(ELEM_W)) u_xbar (
    .src     ({src_b, src_a}),
    .src_idx (src_idx),
    .dst     (perm)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      dst_a       <= '0;
      dst_b       <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_illegal <= !legal;
      if (legal) begin
        dst_a <= perm[VEC_W-1:0];
        dst_b <= perm[2*VEC_W-1:VEC_W];
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vperm_checker.sv
module vperm_checker
  import vperm_pkg::*;
#(
  parameter int ELEM_W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [2:0]                  op,
  input logic [1:0]                  range_lo,
  input logic [1:0]                  range_hi,
  input logic [VP_NELEM*ELEM_W-1:0]  src_b,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic                        out_illegal,
  input logic [VP_NELEM*ELEM_W-1:0]  dst_a,
  input logic [VP_NELEM*ELEM_W-1:0]  dst_b
);

  logic take;
  assign take = in_valid && in_ready;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal && dst_a == '0 && dst_b == '0));

  p_take_valid_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(dst_a) && $stable(dst_b)
                                   && $stable(out_illegal)));

  p_stall_block_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_reject_keep_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> (!out_illegal || (dst_a == $past(dst_a) && dst_b == $past(dst_b))));

  p_rsvd_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (take && op == 3'd7) |=> out_illegal);

  p_pair_span_r7: assert property (@(posedge clk) disable iff (rst)
    (take && op == 3'd5 && (range_lo != 2'd0 || range_hi != 2'd3)) |=> out_illegal);

  p_second_pass_r11: assert property (@(posedge clk) disable iff (rst)
    (take && op == 3'd2 && range_lo == 2'd0 && range_hi == 2'd3)
      |=> (!out_illegal && dst_b == $past(src_b)));

endmodule

bind vperm_shuffle_unit vperm_checker #(.ELEM_W(ELEM_W)) i_vperm_checker (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .op          (op),
  .range_lo    (range_lo),
  .range_hi    (range_hi),
  .src_b       (src_b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_illegal (out_illegal),
  .dst_a       (dst_a),
  .dst_b       (dst_b)
);

// File: tb/test_vperm_shuffle_unit.sv
module test_vperm_shuffle_unit;

  localparam int W  = 16;
  localparam int NE = 64;
  localparam int VW = NE * W;
  typedef logic [VW-1:0] vec_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] op = '0;
  logic [1:0] range_lo = '0;
  logic [1:0] range_hi = '0;
  vec_t       src_a = '0;
  vec_t       src_b = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_illegal;
  vec_t       dst_a;
  vec_t       dst_b;

  int   n_checks = 0;
  int   n_errors = 0;
  vec_t last_a = '0;
  vec_t last_b = '0;

  always #5 clk = ~clk;

  vperm_shuffle_unit #(.ELEM_W(W)) i_vperm_shuffle_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .range_lo(range_lo), .range_hi(range_hi),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_illegal(out_illegal),
    .dst_a(dst_a), .dst_b(dst_b)
  );

  function automatic vec_t pat(input int k, input int base);
    vec_t v;
    for (int i = 0; i < NE; i++) v[i*W +: W] = W'((k << 8) | ((base + i * 5) & 8'hff));
    return v;
  endfunction

  function automatic int brev(input int v, input int n);
    int r = 0;
    for (int i = 0; i < n; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  function automatic bit legal_rng(input int o, input int lo, input int hi);
    if (o == 7 || lo > hi) return 1'b0;
    if (o == 0) return 1'b1;
    if (o == 1 || o == 3) return (lo % 2 == 0) && (hi % 2 == 1);
    return (lo == 0) && (hi == 3);
  endfunction

  task automatic model(input int o, input int lo, input int hi, input vec_t a, input vec_t b,
                       output vec_t ea, output vec_t eb, output bit ill);
    logic [W-1:0] s [128];
    logic [W-1:0] t [128];
    ill = !legal_rng(o, lo, hi);
    for (int i = 0; i < NE; i++) begin
      s[i] = a[i*W +: W]; s[NE+i] = b[i*W +: W];
    end
    for (int i = 0; i < 128; i++) t[i] = s[i];
    case (o)
      0: for (int q = lo; q <= hi; q++)
           for (int j = 0; j < 16; j++) t[q*16+j] = s[q*16+brev(j, 4)];
      1: for (int h = lo/2; h <= hi/2; h++)
           for (int j = 0; j < 32; j++) t[h*32+j] = s[h*32+brev(j, 5)];
      2: for (int j = 0; j < 64; j++) t[j] = s[brev(j, 6)];
      3: for (int h = lo/2; h <= hi/2; h++)
           for (int k = 0; k < 16; k++) begin
             t[h*32+2*k] = s[h*32+k]; t[h*32+2*k+1] = s[h*32+16+k];
           end
      4: for (int k = 0; k < 32; k++) begin t[2*k] = s[k]; t[2*k+1] = s[32+k]; end
      5: for (int k = 0; k < 64; k++) begin t[2*k] = s[k]; t[2*k+1] = s[64+k]; end
      6: for (int k = 0; k < 64; k++) begin t[k] = s[2*k]; t[64+k] = s[2*k+1]; end
      default: ;
    endcase
    if (ill) begin
      ea = last_a; eb = last_b;
    end else begin
      for (int i = 0; i < NE; i++) begin
        ea[i*W +: W] = t[i]; eb[i*W +: W] = t[NE+i];
      end
    end
  endtask

  task automatic chk_vec(input string req, input vec_t act, input vec_t exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      for (int i = 0; i < NE; i++)
        if (act[i*W +: W] !== exp[i*W +: W]) begin
          $display("FAIL %s element %0d actual %h expected %h", req, i,
                   act[i*W +: W], exp[i*W +: W]);
          break;
        end
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic launch(input int o, input int lo, input int hi, input vec_t a, input vec_t b);
    @(negedge clk);
    op = 3'(o); range_lo = 2'(lo); range_hi = 2'(hi);
    src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_check(input string req, input int o, input int lo, input int hi,
                           input vec_t a, input vec_t b);
    vec_t ea, eb;
    bit   ill;
    model(o, lo, hi, a, b, ea, eb, ill);
    launch(o, lo, hi, a, b);
    chk_bit({req, " valid"}, out_valid, 1'b1);
    chk_bit({req, " flag"}, out_illegal, ill);
    chk_vec({req, " dst_a"}, dst_a, ea);
    chk_vec({req, " dst_b"}, dst_b, eb);
    if (!ill) begin last_a = ea; last_b = eb; end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_bit("R1 out_valid", out_valid, 1'b0);
    chk_bit("R1 out_illegal", out_illegal, 1'b0);
    chk_bit("R1 in_ready", in_ready, 1'b1);
    chk_vec("R1 dst_a", dst_a, '0);
    chk_vec("R1 dst_b", dst_b, '0);
  endtask

  task automatic t_rev;
    run_check("R3 rev64", 2, 0, 3, pat(1, 0), pat(2, 7));
    run_check("R4 rev32 both", 1, 0, 3, pat(3, 1), pat(4, 2));
    run_check("R4 R9 rev32 upper", 1, 2, 3, pat(5, 3), pat(6, 0));
    run_check("R5 rev16 all", 0, 0, 3, pat(7, 0), pat(8, 0));
    run_check("R5 R9 rev16 middle", 0, 1, 2, pat(9, 4), pat(10, 1));
    run_check("R5 rev16 single", 0, 3, 3, pat(11, 9), pat(12, 2));
  endtask

  task automatic t_rev16_order;
    int   ord [16] = '{0, 8, 4, 12, 2, 10, 6, 14, 1, 9, 5, 13, 3, 11, 7, 15};
    vec_t a = pat(13, 0);
    vec_t e = a;
    launch(0, 0, 0, a, '0);
    for (int i = 0; i < 16; i++) e[i*W +: W] = a[ord[i]*W +: W];
    chk_vec("R5 listed order", dst_a, e);
    last_a = dst_a; last_b = dst_b;
  endtask

  task automatic t_shuffle;
    vec_t a = pat(14, 0);
    run_check("R6 shf32 both", 3, 0, 3, a, pat(15, 0));
    chk_bit("R6 shf32 slot1 from 16", dst_a[1*W +: W] == a[16*W +: W], 1'b1);
    run_check("R6 R9 shf32 lower", 3, 0, 1, pat(16, 3), pat(17, 3));
    run_check("R6 shf64", 4, 0, 3, pat(18, 5), pat(19, 6));
    run_check("R7 shf128", 5, 0, 3, pat(20, 0), pat(21, 1));
    run_check("R8 uns128", 6, 0, 3, pat(22, 2), pat(23, 8));
  endtask

  task automatic t_illegal;
    run_check("R10 rev32 misaligned", 1, 1, 2, pat(24, 0), pat(25, 0));
    run_check("R10 rev16 reversed bounds", 0, 2, 1, pat(26, 0), pat(27, 0));
    run_check("R10 R7 shf128 partial", 5, 0, 2, pat(28, 0), pat(29, 0));
    run_check("R10 shf64 partial", 4, 1, 3, pat(30, 0), pat(31, 0));
    run_check("R10 reserved code", 7, 0, 3, pat(32, 0), pat(33, 0));
    run_check("R10 recovery legal", 2, 0, 3, pat(34, 0), pat(35, 0));
  endtask

  task automatic t_second_pass;
    vec_t b = pat(36, 11);
    launch(0, 0, 3, pat(37, 0), b);
    chk_vec("R11 rev16 dst_b", dst_b, b);
    launch(4, 0, 3, pat(38, 0), b);
    chk_vec("R11 shf64 dst_b", dst_b, b);
    last_a = dst_a; last_b = dst_b;
  endtask

  task automatic t_identity;
    vec_t a = pat(39, 3);
    vec_t b = pat(40, 4);
    vec_t ma, mb;
    launch(2, 0, 3, a, b);
    launch(2, 0, 3, dst_a, dst_b);
    chk_vec("R12 rev64 twice", dst_a, a);
    launch(0, 1, 3, a, b);
    launch(0, 1, 3, dst_a, dst_b);
    chk_vec("R12 rev16 twice", dst_a, a);
    launch(1, 0, 1, a, b);
    launch(1, 0, 1, dst_a, dst_b);
    chk_vec("R12 rev32 twice", dst_a, a);
    launch(5, 0, 3, a, b);
    ma = dst_a; mb = dst_b;
    launch(6, 0, 3, ma, mb);
    chk_vec("R12 shuffle-unshuffle a", dst_a, a);
    chk_vec("R12 shuffle-unshuffle b", dst_b, b);
    last_a = dst_a; last_b = dst_b;
  endtask

  task automatic t_stall;
    vec_t ea, eb, h_a;
    bit   ill;
    out_ready = 1'b0;
    launch(2, 0, 3, pat(41, 0), pat(42, 0));
    h_a = dst_a;
    chk_bit("R2 valid under stall", out_valid, 1'b1);
    model(4, 0, 3, pat(43, 2), pat(44, 2), ea, eb, ill);
    op = 3'd4; range_lo = 2'd0; range_hi = 2'd3;
    src_a = pat(43, 2); src_b = pat(44, 2); in_valid = 1'b1;
    #1;
    chk_bit("R2 ready low under stall", in_ready, 1'b0);
    @(negedge clk);
    chk_bit("R2 valid held", out_valid, 1'b1);
    chk_vec("R2 dst_a held", dst_a, h_a);
    out_ready = 1'b1;
    #1;
    chk_bit("R2 ready on release", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R2 pending op result", dst_a, ea);
    @(negedge clk);
    chk_bit("R2 valid drops when drained", out_valid, 1'b0);
    last_a = dst_a; last_b = dst_b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rev();
    t_rev16_order();
    t_shuffle();
    t_illegal();
    t_second_pass();
    t_identity();
    t_stall();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule